// File: doc/BRIEF.md
# Interrupt and Reset Vector Sequencer

This block sits beside the control unit of a small 8-bit processor and decides when the program counter must be redirected to a service routine. It watches three active-low lines (a reset line, a non-maskable interrupt line and a maskable interrupt line). It picks the most urgent request and then reads a 16-bit handler address from the top of memory, one byte at a time. It hands that address to the core as a program-counter load.

For the two interrupt kinds, the sequencer first saves the return context. It offers the current PC and the status byte, one byte at a time, on a request/acknowledge push port that the stack logic consumes. After the last byte is accepted it raises a request to set the interrupt-disable flag. A reset request saves nothing. It also takes effect at once, abandoning any sequence already in progress. Interrupts are taken only when the core signals an instruction boundary.

Top module: `irq_vec_seq`

## Requirements
- R1: After the synchronous reset `rst` is released, the first bus activity is the reset vector read (0xFFFE then 0xFFFF) followed by a PC load, whatever the levels of `nmi_n`, `irq_n` and `int_mask`; no push is requested for it.
- R2: Memory reads have a latency of one cycle: the byte addressed while `mem_rd` is high appears on `mem_rdata` in the next cycle. The vector bytes are read low address first in consecutive cycles. In the cycle after the last read, `pc_load` and `done` are both high for exactly one cycle, and `pc_value` = {byte at vector+1, byte at vector}.
- R3: When `ext_reset_n` is low at a rising edge, any push or fetch is abandoned from the next cycle on. `push_req` and `mem_rd` stay low and `busy` stays high while the line stays low. After release the reset vector is fetched with no push.
- R4: The non-maskable request is latched on a high-to-low transition of `nmi_n`. A line held low produces a single service. A line already low when reset is released produces none.
- R5: The maskable request is the level of `irq_n` (low = request). It is ignored whenever `int_mask` is 1.
- R6: When both interrupt kinds are pending at a boundary, the non-maskable one is served first.
- R7: Interrupt requests are accepted only in a cycle with `insn_end` high while the sequencer is idle; until then they stay pending (non-maskable) or are re-evaluated (maskable).
- R8: On acceptance of an interrupt, `pc_now` and `psr_now` are captured. Bytes are offered on `push_data` in the order PC[15:8], PC[7:0], status. Each byte is held stable with `push_req` high until `push_ack` is seen high.
- R9: `set_idis` is high for one cycle, exactly in the cycle the status byte is accepted; it never rises for a reset.
- R10: Vector locations: maskable at 0xFFFA, non-maskable at 0xFFFC, reset at 0xFFFE; no read ever leaves the range 0xFFFA..0xFFFF.
- R11: `busy` is low only when the sequencer is idle and able to accept a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_reset_n | input | 1 | External reset request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active low, edge-latched |
| irq_n | input | 1 | Maskable interrupt, active low, level |
| int_mask | input | 1 | Current interrupt-disable flag from the core |
| insn_end | input | 1 | High in a cycle that ends an instruction |
| pc_now | input | ADDR_W | Current program counter (return address) |
| psr_now | input | 8 | Current status byte |
| mem_addr | output | ADDR_W | Vector read address |
| mem_rd | output | 1 | Read strobe, one byte per cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| push_req | output | 1 | Push request to the stack logic |
| push_data | output | 8 | Byte offered for pushing |
| push_ack | input | 1 | Stack logic accepts the offered byte |
| set_idis | output | 1 | Pulse: set the interrupt-disable flag |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | ADDR_W | Assembled vector address |
| done | output | 1 | One-cycle pulse when the PC load is complete |
| busy | output | 1 | Sequencer is not idle |

## Verification
The bench builds the block with ADDR_W = 16. With that value the three vectors land on 0xFFFA, 0xFFFC and 0xFFFE and the return frame is three bytes, so every address and byte order can be compared against plain constants. The stack side acknowledges with a selectable delay, which exposes the hold-until-accepted rule. It also allows a reset-line abort to be placed between two pushed bytes. Boundary gating, masking, edge latching of the non-maskable line and the priority between the two kinds are driven in separate phases.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;

    localparam int BYTE_W = 8;

    // Order is behaviour: the source code times the vector width gives
    // the vector's offset from the base of the vector area.
    typedef enum logic [1:0] {
        SRC_IRQ = 2'd0,
        SRC_NMI = 2'd1,
        SRC_RST = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_IDLE,
        SQ_HOLD,
        SQ_PUSH,
        SQ_FETCH,
        SQ_LOAD
    } sq_state_e;

    function automatic int vec_offset(input src_e src, input int nbytes);
        return int'(src) * nbytes;
    endfunction

endpackage

// File: rtl/irqv_arbiter.sv
`timescale 1ns/1ps
module irqv_arbiter
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_reset_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic int_mask,
    input  logic insn_end,
    input  logic idle,
    output logic req_valid,
    output src_e req_src
);

    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_fall;
    logic irq_live;

    // Previous level tracks the pin even in reset, so a line already low
    // at release is not seen as an edge.
    always_ff @(posedge clk) begin
        nmi_prev_q <= nmi_n;
    end

    assign nmi_fall = nmi_prev_q && !nmi_n;
    assign irq_live = !irq_n && !int_mask;

    assign req_valid = idle && insn_end && ext_reset_n && (nmi_pend_q || irq_live);
    assign req_src   = nmi_pend_q ? SRC_NMI : SRC_IRQ;

    always_ff @(posedge clk) begin
        if (rst || !ext_reset_n) begin
            nmi_pend_q <= 1'b0;
        end else if (nmi_fall) begin
            nmi_pend_q <= 1'b1;
        end else if (req_valid && req_src == SRC_NMI) begin
            nmi_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irqv_seq.sv
`timescale 1ns/1ps
module irqv_seq
    import irqv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_reset_n,
    input  logic              req_valid,
    input  src_e              req_src,
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [BYTE_W-1:0] psr_now,
    input  logic              push_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              idle,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              push_req,
    output logic [BYTE_W-1:0] push_data,
    output logic              set_idis,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              done
);

    localparam int PC_BYTES = ADDR_W / BYTE_W;
    localparam int PUSH_N   = PC_BYTES + 1;
    localparam int CNT_W    = $clog2(PUSH_N) + 1;
    localparam logic [ADDR_W-1:0] VEC_SPAN = ADDR_W'(3 * PC_BYTES);
    localparam logic [ADDR_W-1:0] VEC_BASE = ~(VEC_SPAN - ADDR_W'(1));
    localparam logic [CNT_W-1:0]  PUSH_LAST  = CNT_W'(PUSH_N - 1);
    localparam logic [CNT_W-1:0]  FETCH_LAST = CNT_W'(PC_BYTES - 1);

    sq_state_e         st_q, st_d;
    src_e              src_q, src_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] pc_sav_q;
    logic [BYTE_W-1:0] psr_sav_q;
    logic              cap_pend_q;
    logic [CNT_W-1:0]  cap_idx_q;
    logic [BYTE_W-1:0] asm_q   [PC_BYTES];
    logic [BYTE_W-1:0] pc_byte [PC_BYTES];
    logic [ADDR_W-1:0] vec_addr;

    // Next-state logic; the external reset line overrides every state.
    always_comb begin
        st_d  = st_q;
        src_d = src_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SQ_BOOT: begin
                st_d  = SQ_FETCH;
                src_d = SRC_RST;
                cnt_d = '0;
            end
            SQ_IDLE: begin
                if (req_valid) begin
                    st_d  = SQ_PUSH;
                    src_d = req_src;
                    cnt_d = '0;
                end
            end
            SQ_PUSH: begin
                if (push_ack) begin
                    if (cnt_q == PUSH_LAST) begin
                        st_d  = SQ_FETCH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SQ_FETCH: begin
                if (cnt_q == FETCH_LAST) begin
                    st_d  = SQ_LOAD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_LOAD: begin
                st_d = SQ_IDLE;
            end
            SQ_HOLD: begin
                if (ext_reset_n) begin
                    st_d  = SQ_FETCH;
                    src_d = SRC_RST;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d = SQ_IDLE;
            end
        endcase
        if (!ext_reset_n) begin
            st_d  = SQ_HOLD;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_BOOT;
            src_q      <= SRC_RST;
            cnt_q      <= '0;
            cap_pend_q <= 1'b0;
            cap_idx_q  <= '0;
            pc_sav_q   <= '0;
            psr_sav_q  <= '0;
        end else begin
            st_q       <= st_d;
            src_q      <= src_d;
            cnt_q      <= cnt_d;
            cap_pend_q <= (st_q == SQ_FETCH);
            cap_idx_q  <= cnt_q;
            if (st_q == SQ_IDLE && req_valid) begin
                pc_sav_q  <= pc_now;
                psr_sav_q <= psr_now;
            end
        end
    end

    // Byte slicing of the saved PC and assembly of the fetched vector.
    for (genvar g = 0; g < PC_BYTES; g++) begin : g_bytes
        assign pc_byte[g] = pc_sav_q[g*BYTE_W +: BYTE_W];

        always_ff @(posedge clk) begin
            if (cap_pend_q && cap_idx_q == CNT_W'(g)) begin
                asm_q[g] <= mem_rdata;
            end
        end

        if (g == PC_BYTES - 1) begin : g_top
            assign pc_value[g*BYTE_W +: BYTE_W] = mem_rdata;
        end else begin : g_low
            assign pc_value[g*BYTE_W +: BYTE_W] = asm_q[g];
        end
    end

    always_comb begin
        push_data = psr_sav_q;
        for (int i = 0; i < PC_BYTES; i++) begin
            if (cnt_q == CNT_W'(i)) begin
                push_data = pc_byte[PC_BYTES-1-i];
            end
        end
    end

    assign vec_addr = VEC_BASE + ADDR_W'(vec_offset(src_q, PC_BYTES));
    assign mem_addr = vec_addr + ADDR_W'(cnt_q);

    assign idle     = (st_q == SQ_IDLE);
    assign busy     = !idle;
    assign mem_rd   = (st_q == SQ_FETCH);
    assign push_req = (st_q == SQ_PUSH);
    assign set_idis = push_req && push_ack && (cnt_q == PUSH_LAST);
    assign pc_load  = (st_q == SQ_LOAD);
    assign done     = pc_load;

endmodule

// File: rtl/irq_vec_seq.sv
`timescale 1ns/1ps
module irq_vec_seq
    import irqv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_reset_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              int_mask,
    input  logic              insn_end,
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [7:0]        psr_now,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              push_req,
    output logic [7:0]        push_data,
    input  logic              push_ack,
    output logic              set_idis,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              done,
    output logic              busy
);

    logic idle;
    logic req_valid;
    src_e req_src;

    irqv_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .ext_reset_n (ext_reset_n),
        .nmi_n       (nmi_n),
        .irq_n       (irq_n),
        .int_mask    (int_mask),
        .insn_end    (insn_end),
        .idle        (idle),
        .req_valid   (req_valid),
        .req_src     (req_src)
    );

    irqv_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ext_reset_n (ext_reset_n),
        .req_valid   (req_valid),
        .req_src     (req_src),
        .pc_now      (pc_now),
        .psr_now     (psr_now),
        .push_ack    (push_ack),
        .mem_rdata   (mem_rdata),
        .idle        (idle),
        .busy        (busy),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .push_req    (push_req),
        .push_data   (push_data),
        .set_idis    (set_idis),
        .pc_load     (pc_load),
        .pc_value    (pc_value),
        .done        (done)
    );

endmodule

// File: rtl/irq_vec_seq_chk.sv
`timescale 1ns/1ps
module irq_vec_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_reset_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              push_req,
    input logic              push_ack,
    input logic [7:0]        push_data,
    input logic              set_idis,
    input logic              pc_load,
    input logic              done,
    input logic              busy
);

    localparam int PC_BYTES = ADDR_W / 8;
    localparam logic [ADDR_W-1:0] VEC_LOW = ~(ADDR_W'(3 * PC_BYTES) - ADDR_W'(1));

    // R2: vector reads step through consecutive bytes, then the PC load follows
    assert_read_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && ext_reset_n) |=> ((mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)) || pc_load));

    // R2: a PC load is always preceded by a read
    assert_load_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> $past(mem_rd));

    // R2: the completion pulse lasts one cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: the reset line silences the push and read ports
    assert_reset_abort_R3: assert property (@(posedge clk) disable iff (rst)
        !ext_reset_n |=> (!push_req && !mem_rd && busy));

    // R8: an unaccepted byte stays on offer unchanged
    assert_push_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (push_req && !push_ack && ext_reset_n) |=> (push_req && $stable(push_data)));

    // R9: the mask-set pulse coincides with an accepted push
    assert_idis_on_push_R9: assert property (@(posedge clk) disable iff (rst)
        set_idis |-> (push_req && push_ack));

    // R10: reads stay inside the vector area
    assert_vec_window_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr >= VEC_LOW));

endmodule

bind irq_vec_seq irq_vec_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_reset_n (ext_reset_n),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .push_req    (push_req),
    .push_ack    (push_ack),
    .push_data   (push_data),
    .set_idis    (set_idis),
    .pc_load     (pc_load),
    .done        (done),
    .busy        (busy)
);

// File: tb/irq_vec_seq_tb.sv
`timescale 1ns/1ps
module irq_vec_seq_tb;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              ext_reset_n;
    logic              nmi_n;
    logic              irq_n;
    logic              int_mask;
    logic              insn_end;
    logic [ADDR_W-1:0] pc_now;
    logic [7:0]        psr_now;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [7:0]        mem_rdata = 8'h00;
    logic              push_req;
    logic [7:0]        push_data;
    logic              push_ack = 1'b0;
    logic              set_idis;
    logic              pc_load;
    logic [ADDR_W-1:0] pc_value;
    logic              done;
    logic              busy;

    int n_cmp  = 0;
    int n_bad  = 0;
    int n_push = 0;
    int ack_wait = 0;
    int ack_cnt  = 0;
    logic [17:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_vec_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .ext_reset_n(ext_reset_n), .nmi_n(nmi_n),
        .irq_n(irq_n), .int_mask(int_mask), .insn_end(insn_end),
        .pc_now(pc_now), .psr_now(psr_now), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_rdata(mem_rdata), .push_req(push_req),
        .push_data(push_data), .push_ack(push_ack), .set_idis(set_idis),
        .pc_load(pc_load), .pc_value(pc_value), .done(done), .busy(busy)
    );

    // Vector contents: IRQ 0x1234, NMI 0x5678, RESET 0x9ABC, little-endian.
    function automatic logic [7:0] vbyte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h78;
            16'hFFFD: return 8'h56;
            16'hFFFE: return 8'hBC;
            16'hFFFF: return 8'h9A;
            default:  return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        mem_rdata <= mem_rd ? vbyte(mem_addr) : 8'h00;
    end

    // Stack side: accept after ack_wait idle cycles of a request.
    always @(negedge clk) begin
        if (push_req) begin
            if (ack_cnt >= ack_wait) begin
                push_ack = 1'b1;
                ack_cnt  = 0;
            end else begin
                push_ack = 1'b0;
                ack_cnt  = ack_cnt + 1;
            end
        end else begin
            push_ack = 1'b0;
            ack_cnt  = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard item: {kind, value}; kind 0 read address, 1 push {idis,byte}, 2 PC load.
    task automatic sb_take(input logic [17:0] got);
        logic [17:0] want;
        string tag;
        tag = (got[17:16] == 2'd0) ? "R10" : (got[17:16] == 2'd1) ? "R8" : "R2";
        if (exp_q.size() == 0) begin
            check(1'b0, {tag, " unexpected event"}, 32'(got), 32'h0);
        end else begin
            want = exp_q.pop_front();
            check(got == want, tag, 32'(got), 32'(want));
        end
    endtask

    task automatic exp_vec(input int src, input logic [15:0] val);
        logic [15:0] base;
        base = 16'hFFFA + 16'(2 * src);
        exp_q.push_back({2'd0, base});
        exp_q.push_back({2'd0, base + 16'd1});
        exp_q.push_back({2'd2, val});
    endtask

    task automatic exp_frame(input logic [15:0] pc, input logic [7:0] psr);
        exp_q.push_back({2'd1, 7'd0, 1'b0, pc[15:8]});
        exp_q.push_back({2'd1, 7'd0, 1'b0, pc[7:0]});
        exp_q.push_back({2'd1, 7'd0, 1'b1, psr});
    endtask

    // Monitor: samples 1 ns after the falling edge; models the core setting the mask.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (mem_rd) sb_take({2'd0, mem_addr});
                if (push_req && push_ack) begin
                    sb_take({2'd1, 7'd0, set_idis, push_data});
                    n_push++;
                    if (set_idis) int_mask = 1'b1;
                end else if (set_idis) begin
                    check(1'b0, "R9 stray set_idis", 32'd1, 32'd0);
                end
                if (pc_load) begin
                    sb_take({2'd2, pc_value});
                    check(done == 1'b1, "R2 done with load", 32'(done), 32'd1);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        check(exp_q.size() == 0, {req, " sequence completed"}, 32'(exp_q.size()), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_check(input int cycles, input string req);
        repeat (cycles) @(negedge clk);
        #1;
        check(busy == 1'b0, {req, " no service taken"}, 32'(busy), 32'd0);
        check(exp_q.size() == 0, {req, " nothing pending"}, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        int base;
        rst = 1'b1; ext_reset_n = 1'b1; nmi_n = 1'b0; irq_n = 1'b0;
        int_mask = 1'b1; insn_end = 1'b1; pc_now = '0; psr_now = '0;
        repeat (3) @(negedge clk);
        #1;
        // Reset state
        check(mem_rd == 1'b0,   "R1 reset mem_rd",   32'(mem_rd),   32'd0);
        check(push_req == 1'b0, "R1 reset push_req", 32'(push_req), 32'd0);
        check(pc_load == 1'b0,  "R1 reset pc_load",  32'(pc_load),  32'd0);
        check(done == 1'b0,     "R1 reset done",     32'(done),     32'd0);

        // R1: boot fetch with NMI already low and IRQ masked
        exp_vec(2, 16'h9ABC);
        @(negedge clk);
        rst = 1'b0;
        drain("R1");
        idle_check(20, "R4 R5 held-low NMI and masked IRQ");

        // R4: NMI falling edge, one service only
        pc_now = 16'h4321; psr_now = 8'hA4;
        nmi_n = 1'b1;
        repeat (2) @(negedge clk);
        exp_frame(16'h4321, 8'hA4);
        exp_vec(1, 16'h5678);
        nmi_n = 1'b0;
        drain("R4");
        idle_check(20, "R4 single service");

        // R5: IRQ masked, then unmasked with slow acknowledge
        idle_check(10, "R5 masked IRQ");
        ack_wait = 2;
        pc_now = 16'h1357; psr_now = 8'h03;
        exp_frame(16'h1357, 8'h03);
        exp_vec(0, 16'h1234);
        int_mask = 1'b0;
        drain("R5");

        // R7: requests wait for the boundary; R6: NMI before IRQ
        ack_wait = 0;
        insn_end = 1'b0;
        nmi_n = 1'b1;
        repeat (2) @(negedge clk);
        nmi_n = 1'b0;
        int_mask = 1'b0;
        pc_now = 16'h2468; psr_now = 8'h11;
        idle_check(10, "R7 no boundary");
        exp_frame(16'h2468, 8'h11);
        exp_vec(1, 16'h5678);
        insn_end = 1'b1;
        drain("R6");
        pc_now = 16'h0ACE; psr_now = 8'h22;
        exp_frame(16'h0ACE, 8'h22);
        exp_vec(0, 16'h1234);
        int_mask = 1'b0;
        drain("R6 second");

        // R3: reset line aborts a push between bytes
        ack_wait = 3;
        pc_now = 16'hBEEF; psr_now = 8'h5A;
        exp_q.push_back({2'd1, 7'd0, 1'b0, 8'hBE});
        base = n_push;
        int_mask = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (n_push != base) break;
        end
        ext_reset_n = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(busy == 1'b1,     "R3 busy in hold",   32'(busy),     32'd1);
        check(push_req == 1'b0, "R3 push abandoned", 32'(push_req), 32'd0);
        check(mem_rd == 1'b0,   "R3 no reads",       32'(mem_rd),   32'd0);
        check(exp_q.size() == 0, "R3 one byte only", 32'(exp_q.size()), 32'd0);
        irq_n = 1'b1;
        @(negedge clk);
        exp_vec(2, 16'h9ABC);
        ext_reset_n = 1'b1;
        drain("R3");
        idle_check(5, "R11 idle after reset fetch");

        finish_run();
    end

endmodule